// File: doc/BRIEF.md
# Threshold-Driven Bus Master with Wait States

This block is the bus-master half of a packet DMA engine. It watches the fill level of an adjacent 16-entry FIFO and raises a bus request when the FIFO has enough work for a burst. In the receive direction that means enough data is waiting to be written to buffer memory. In the transmit direction it means enough free space exists to be filled from memory. Once the arbiter grants the bus, the block runs back-to-back memory cycles. Each cycle has a setup state, two strobe states and any number of wait states added by a ready input.

The address and write data come from outside, from the FIFO and the address generator. The block presents them in the setup state and holds them for the rest of the cycle. A per-cycle completion pulse tells those neighbours to advance. In the transmit direction, read data is captured when the read strobe rises and is then held on an output. The strobes are in high impedance while the bus is not owned. This is modelled by an output-enable flag, and the strobe values sit at their inactive level whenever the flag is low.

Top module: `dma_bus_master`

## Requirements
- R1: `thr_sel` selects a burst threshold T: code 0 gives 2, code 1 gives 4, code 2 gives 8 and code 3 gives 12. While idle, `bus_req` is high exactly when the direction needs service. With `dir_tx`=0 (receive) that is `fifo_level` >= T. With `dir_tx`=1 (transmit) it is 16 - `fifo_level` >= T.
- R2: A memory cycle starts only on a clock edge where `bus_ack` is high and the request is pending. Granting the bus with no request pending starts nothing.
- R3: Whenever the bus is not owned, `strobe_oe` is low and both `rd_n` and `wr_n` are high. This holds after reset, before a grant and after release.
- R4: Each cycle begins with one setup clock in which both strobes are high. The cycle continues with the strobe for the direction held low: `rd_n` when transmitting, `wr_n` when receiving. The other strobe stays high.
- R5: `ready` is sampled at the end of the second strobe-low clock and at the end of every wait clock. A high sample adds one more low clock. `ready` is ignored in the setup clock and in the first low clock, so the strobe is low for 2 + W clocks, where W is the number of high samples.
- R6: `addr` follows `next_addr` during the setup clock. From the edge that ends setup, `addr` holds that value until the cycle ends.
- R7: When receiving, `dout` carries `wr_data` taken at the end of setup and keeps it until the write strobe rises.
- R8: When transmitting, `din` is captured on the edge where `rd_n` returns high. It appears on `rd_data` from the next clock and holds until the next capture.
- R9: `xfer_done` is high only in the final strobe-low clock of a cycle, which is the clock in which `ready` is low at the sample point.
- R10: A burst is exactly T back-to-back cycles, each new setup following the previous completion directly. After the last cycle `strobe_oe` falls and `bus_req` stays low for one clock. The request is then evaluated again by R1.
- R11: If `bus_ack` falls during a cycle, that cycle still completes at full length. `strobe_oe` then falls, and `bus_req` again follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_tx | input | 1 | 1 = transmit (memory to FIFO, read cycles), 0 = receive (FIFO to memory, write cycles) |
| thr_sel | input | 2 | Burst threshold code |
| fifo_level | input | 5 | Current FIFO occupancy, 0 to 16 |
| next_addr | input | 16 | Address for the next memory cycle |
| wr_data | input | 8 | Data for the next write cycle |
| bus_req | output | 1 | Bus request, active high |
| bus_ack | input | 1 | Bus grant, active high |
| ready | input | 1 | High to insert a wait state |
| strobe_oe | output | 1 | Strobes and address are driven (not high impedance) |
| rd_n | output | 1 | Memory read strobe, active low |
| wr_n | output | 1 | Memory write strobe, active low |
| addr | output | 16 | Memory address |
| dout | output | 8 | Write data to memory |
| din | input | 8 | Read data from memory |
| rd_data | output | 8 | Last captured read data |
| xfer_done | output | 1 | Final clock of a memory cycle |

## Verification
The assertions place no constraint on `ready` or `bus_ack`: both may change on any clock. They do assume that `dir_tx`, `thr_sel` and `fifo_level` stay steady while a burst is in progress, because the block samples the threshold throughout the burst. The stimulus keeps those three fixed from the moment the grant is raised until the release is observed. Each cycle's wait count, each drop point for the grant and the data and address values are drawn at random. `ready` is also randomised in the clocks where it must be ignored.

// File: rtl/dma_bm_pkg.sv
// Package for the threshold-driven bus master: the cycle state encoding
// and the decode from threshold code to byte count.
package dma_bm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4
    } bus_state_e;

    // Threshold code to byte count; upper codes scale with FIFO depth.
    function automatic int unsigned thr_bytes(input logic [1:0] code,
                                              input int unsigned depth);
        case (code)
            2'd0:    return 2;
            2'd1:    return 4;
            2'd2:    return depth / 2;
            default: return (depth * 3) / 4;
        endcase
    endfunction

endpackage

// File: rtl/dma_req_gen.sv
// Request generator: decides whether the FIFO needs servicing and drives
// the bus request. Assumes level, direction and threshold are steady while
// a burst is running. A one-clock rest follows every completed burst.
module dma_req_gen #(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_tx,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] thr_val,
    input  logic             is_idle,
    input  logic             last_beat,
    output logic             start_ok,
    output logic             bus_req
);

    logic [LVL_W-1:0] free_cnt;
    logic             need;
    logic             rest_q;

    // Service test: data waiting (receive) or space free (transmit).
    always_comb begin
        free_cnt = LVL_W'(FIFO_DEPTH) - fifo_level;
        need     = dir_tx ? (free_cnt >= thr_val) : (fifo_level >= thr_val);
    end

    // Rest flag: holds the request low for one clock after a full burst.
    always_ff @(posedge clk) begin
        if (!rst_n) rest_q <= 1'b0;
        else        rest_q <= last_beat;
    end

    // Request is held through a burst, otherwise follows the service test.
    always_comb begin
        start_ok = need && !rest_q;
        bus_req  = !is_idle || start_ok;
    end

endmodule

// File: rtl/dma_cycle_fsm.sv
// Cycle sequencer: walks T1, T2, T3 and wait states, counts the beats of
// a burst and decides between another cycle and releasing the bus.
// Assumes thr_val is at least 1 and steady during a burst.
module dma_cycle_fsm
    import dma_bm_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
    localparam int CW    = LVL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             bus_ack,
    input  logic             ready,
    input  logic [LVL_W-1:0] thr_val,
    output bus_state_e       state,
    output logic             cyc_end,
    output logic             last_beat
);

    bus_state_e       state_q;
    bus_state_e       state_d;
    logic [LVL_W-1:0] beat_q;
    logic             in_sample;
    logic             leave;

    // Completion and last-beat decode.
    always_comb begin
        in_sample = (state_q == ST_T3) || (state_q == ST_TW);
        cyc_end   = in_sample && !ready;
        last_beat = cyc_end &&
                    (({1'b0, beat_q} + CW'(1)) >= {1'b0, thr_val});
        leave     = last_beat || !bus_ack;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start_ok && bus_ack) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3, ST_TW: begin
                if (ready)      state_d = ST_TW;
                else if (leave) state_d = ST_IDLE;
                else            state_d = ST_T1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Beat counter: cleared while idle, advanced at each completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                  beat_q <= '0;
        else if (state_q == ST_IDLE) beat_q <= '0;
        else if (cyc_end)            beat_q <= beat_q + LVL_W'(1);
    end

    assign state = state_q;

endmodule

// File: rtl/dma_bus_drive.sv
// Bus driver: turns the cycle state into strobes, holds address and write
// data from the end of T1 and captures read data at the read-strobe rise.
// Direction is latched while idle so it cannot change inside a burst.
module dma_bus_drive
    import dma_bm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              cyc_end,
    input  logic              dir_tx,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] din,
    output logic              strobe_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rd_data
);

    logic              dir_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] dout_q;
    logic [DATA_W-1:0] rd_q;
    logic              in_t1;
    logic              low_ph;

    // Phase decode.
    always_comb begin
        in_t1  = (state == ST_T1);
        low_ph = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
    end

    // Direction latch, open only while the bus is not owned.
    always_ff @(posedge clk) begin
        if (!rst_n)              dir_q <= 1'b0;
        else if (state == ST_IDLE) dir_q <= dir_tx;
    end

    // Address and write-data hold registers, loaded at the end of T1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dout_q <= '0;
        end else if (in_t1) begin
            addr_q <= next_addr;
            dout_q <= wr_data;
        end
    end

    // Read-data capture on the edge that ends a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                rd_q <= '0;
        else if (cyc_end && dir_q) rd_q <= din;
    end

    // Strobe, enable and bus value outputs.
    always_comb begin
        strobe_oe = (state != ST_IDLE);
        rd_n      = !(low_ph && dir_q);
        wr_n      = !(low_ph && !dir_q);
        addr      = in_t1 ? next_addr : addr_q;
        dout      = in_t1 ? wr_data   : dout_q;
        rd_data   = rd_q;
    end

endmodule

// File: rtl/dma_bus_master.sv
// Top of the threshold-driven bus master. Connects the request generator,
// the cycle sequencer and the bus driver. Assumes a FIFO depth of at least
// 4 so that every threshold code decodes to a nonzero count.
module dma_bus_master
    import dma_bm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_tx,
    input  logic [1:0]        thr_sel,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              bus_req,
    input  logic              bus_ack,
    input  logic              ready,
    output logic              strobe_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data,
    output logic              xfer_done
);

    logic [LVL_W-1:0] thr_val;
    logic             start_ok;
    logic             cyc_end;
    logic             last_beat;
    bus_state_e       state;

    // Threshold decode.
    always_comb thr_val = LVL_W'(thr_bytes(thr_sel, FIFO_DEPTH));

    dma_req_gen #(.FIFO_DEPTH(FIFO_DEPTH)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_tx     (dir_tx),
        .fifo_level (fifo_level),
        .thr_val    (thr_val),
        .is_idle    (state == ST_IDLE),
        .last_beat  (last_beat),
        .start_ok   (start_ok),
        .bus_req    (bus_req)
    );

    dma_cycle_fsm #(.FIFO_DEPTH(FIFO_DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok   (start_ok),
        .bus_ack    (bus_ack),
        .ready      (ready),
        .thr_val    (thr_val),
        .state      (state),
        .cyc_end    (cyc_end),
        .last_beat  (last_beat)
    );

    dma_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .cyc_end    (cyc_end),
        .dir_tx     (dir_tx),
        .next_addr  (next_addr),
        .wr_data    (wr_data),
        .din        (din),
        .strobe_oe  (strobe_oe),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .dout       (dout),
        .rd_data    (rd_data)
    );

    assign xfer_done = cyc_end;

endmodule

// File: rtl/dma_bus_master_chk.sv
// Checker for the bus master, observing its ports only. Bound to every
// instance of the top module.
module dma_bus_master_chk #(
    parameter int ADDR_W = 16,
    parameter int LVL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_tx,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              ready,
    input logic              strobe_oe,
    input logic              rd_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic              xfer_done
);

    logic strb_low;
    assign strb_low = !rd_n || !wr_n;

    // R1
    rx_low_level_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_oe && !dir_tx && (fifo_level < LVL_W'(2))) |-> !bus_req);

    // R2
    start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_oe) |-> $past(bus_ack));

    // R3
    idle_strobes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_oe |-> (rd_n && wr_n));

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5
    wait_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_low && $past(strb_low) && ready) |=> strb_low);

    // R6
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_low && $past(strb_low)) |-> $stable(addr));

    // R9
    done_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (strb_low && !ready));

endmodule

bind dma_bus_master dma_bus_master_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_tx     (dir_tx),
    .fifo_level (fifo_level),
    .bus_req    (bus_req),
    .bus_ack    (bus_ack),
    .ready      (ready),
    .strobe_oe  (strobe_oe),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .xfer_done  (xfer_done)
);

// File: tb/dma_bus_master_tb.sv
module dma_bus_master_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dir_tx;
    logic [1:0]  thr_sel;
    logic [4:0]  fifo_level;
    logic [15:0] next_addr;
    logic [7:0]  wr_data;
    logic        bus_req;
    logic        bus_ack;
    logic        ready;
    logic        strobe_oe;
    logic        rd_n;
    logic        wr_n;
    logic [15:0] addr;
    logic [7:0]  dout;
    logic [7:0]  din;
    logic [7:0]  rd_data;
    logic        xfer_done;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_bus_master u_dut (
        .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .thr_sel(thr_sel),
        .fifo_level(fifo_level), .next_addr(next_addr), .wr_data(wr_data),
        .bus_req(bus_req), .bus_ack(bus_ack), .ready(ready),
        .strobe_oe(strobe_oe), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .dout(dout), .din(din), .rd_data(rd_data), .xfer_done(xfer_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int thr_of(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            default: return 12;
        endcase
    endfunction

    function automatic bit need_of(input bit d, input int code, input int lvl);
        if (d) return (16 - lvl) >= thr_of(code);
        return lvl >= thr_of(code);
    endfunction

    // Idle request check at a given level (R1).
    task automatic check_req(input bit d, input int code, input int lvl);
        bus_ack    = 1'b0;
        dir_tx     = d;
        thr_sel    = 2'(code);
        fifo_level = 5'(lvl);
        step();
        chk(bus_req == need_of(d, code, lvl), "R1", "idle request level",
            int'(bus_req), int'(need_of(d, code, lvl)));
    endtask

    // One burst; wd_at > 0 drops the grant in that cycle (R11).
    task automatic run_burst(input bit d, input int code, input int lvl, input int wd_at);
        int  thr;
        bit  need;
        int  cycles;
        int  low;
        int  waits;
        int  guard;
        bit  withdrawn;
        bit  between;
        bit  have_rd;
        int  exp_rd;
        int  cur_a;
        int  cur_d;
        bit  exp_done;
        thr        = thr_of(code);
        need       = need_of(d, code, lvl);
        dir_tx     = d;
        thr_sel    = 2'(code);
        fifo_level = 5'(lvl);
        bus_ack    = 1'b0;
        next_addr  = 16'($urandom);
        wr_data    = 8'($urandom);
        ready      = 1'($urandom);
        step();
        step();
        chk(bus_req == need, "R1", "request before grant", int'(bus_req), int'(need));
        chk(!strobe_oe && rd_n && wr_n, "R3", "strobes idle before grant",
            int'({strobe_oe, rd_n, wr_n}), 3);
        if (!need) begin
            bus_ack = 1'b1;
            step();
            step();
            chk(!strobe_oe, "R2", "grant without request starts nothing", int'(strobe_oe), 0);
            bus_ack = 1'b0;
            return;
        end
        bus_ack   = 1'b1;
        cycles    = 0;
        low       = 0;
        waits     = int'($urandom % 4);
        withdrawn = 1'b0;
        between   = 1'b1;
        have_rd   = 1'b0;
        exp_rd    = 0;
        cur_a     = int'(next_addr);
        cur_d     = int'(wr_data);
        guard     = 0;
        while (guard < 400) begin
            guard++;
            step();
            if (have_rd) begin
                chk(int'(rd_data) == exp_rd, "R8", "captured read data", int'(rd_data), exp_rd);
                have_rd = 1'b0;
            end
            if (between) begin
                between = 1'b0;
                if (cycles == thr) begin
                    chk(!strobe_oe && !bus_req, "R10", "release after full burst",
                        int'({strobe_oe, bus_req}), 0);
                    bus_ack = 1'b0;
                    step();
                    chk(bus_req == need, "R10", "request reevaluated after rest",
                        int'(bus_req), int'(need));
                    return;
                end
                if (withdrawn) begin
                    chk(!strobe_oe && rd_n && wr_n, "R11", "release after grant drop",
                        int'({strobe_oe, rd_n, wr_n}), 3);
                    chk(bus_req == need, "R11", "request after grant drop",
                        int'(bus_req), int'(need));
                    return;
                end
                chk(strobe_oe && rd_n && wr_n, "R4", "setup clock strobes high",
                    int'({strobe_oe, rd_n, wr_n}), 7);
                ready = 1'($urandom);
                continue;
            end
            if (!rd_n || !wr_n) begin
                low++;
                if (low == 1) begin
                    chk(int'(addr) == cur_a, "R6", "address held in cycle", int'(addr), cur_a);
                    if (d) chk(!rd_n && wr_n, "R4", "read strobe only", int'({rd_n, wr_n}), 1);
                    else   chk(!wr_n && rd_n, "R4", "write strobe only", int'({rd_n, wr_n}), 2);
                    if (wd_at == cycles + 1) begin
                        bus_ack   = 1'b0;
                        withdrawn = 1'b1;
                    end
                end
                ready = (low >= 2) ? (low - 2 < waits) : 1'($urandom);
                din   = 8'($urandom);
                #1;
                exp_done = (low >= 2) && (low - 2 == waits);
                chk(xfer_done == exp_done, "R5", "wait-stretched completion",
                    int'(xfer_done), int'(exp_done));
                chk(int'(addr) == cur_a, "R6", "address stable while low", int'(addr), cur_a);
                if (exp_done) begin
                    if (!d) chk(int'(dout) == cur_d, "R7", "write data at strobe rise",
                                int'(dout), cur_d);
                    else begin
                        exp_rd  = int'(din);
                        have_rd = 1'b1;
                    end
                    chk(xfer_done, "R9", "done in final clock", int'(xfer_done), 1);
                    cycles++;
                    low       = 0;
                    between   = 1'b1;
                    waits     = int'($urandom % 4);
                    next_addr = 16'($urandom);
                    wr_data   = 8'($urandom);
                    cur_a     = int'(next_addr);
                    cur_d     = int'(wr_data);
                end
            end else begin
                chk(1'b0, "R5", "strobe rose before completion", low, 2 + waits);
                return;
            end
        end
        chk(1'b0, "R10", "watchdog expired in burst", guard, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n      = 1'b0;
        dir_tx     = 1'b0;
        thr_sel    = 2'd0;
        fifo_level = 5'd0;
        next_addr  = '0;
        wr_data    = '0;
        bus_ack    = 1'b0;
        ready      = 1'b0;
        din        = '0;
        repeat (3) step();
        chk(!strobe_oe && rd_n && wr_n, "R3", "reset strobes idle",
            int'({strobe_oe, rd_n, wr_n}), 3);
        chk(!bus_req && !xfer_done, "R1", "reset no request", int'({bus_req, xfer_done}), 0);
        rst_n = 1'b1;
        step();

        // Threshold boundaries in both directions (R1).
        for (int c = 0; c < 4; c++) begin
            check_req(1'b0, c, thr_of(c) - 1);
            check_req(1'b0, c, thr_of(c));
            check_req(1'b1, c, 16 - thr_of(c));
            check_req(1'b1, c, 17 - thr_of(c));
        end

        // Directed bursts: smallest, largest, grant drop, no request (R2).
        run_burst(1'b0, 0, 2, 0);
        run_burst(1'b1, 3, 0, 0);
        run_burst(1'b0, 2, 10, 3);
        run_burst(1'b1, 1, 14, 0);
        run_burst(1'b0, 3, 16, 1);

        // Random bursts.
        for (int i = 0; i < 60; i++) begin
            int c;
            int t;
            int wd;
            c  = int'($urandom % 4);
            t  = thr_of(c);
            wd = (($urandom % 3) == 0) ? 1 + int'($urandom % (t - 1)) : 0;
            run_burst(1'($urandom), c, int'($urandom % 17), wd);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule